// File: doc/BRIEF.md
# DDS SPI Register Access Engine

This block is an SPI master that reaches the register file of a direct digital synthesizer. Every access is a two-phase frame sent under one chip-select assertion. A 16-bit instruction word goes first; it holds a read flag, a byte count and a register address. A data phase of one to four bytes follows. Write data is taken from the top of a 32-bit word. Read data is collected from the serial input and returned right-aligned.

A second command, the profile update, streams a 16-bit phase word and a 48-bit frequency tuning word into the device in one burst. When chip-select is released, the block raises an IO-update strobe for a fixed number of clocks, so the device applies the new frequency and phase together.

The user side is a valid/ready request port and a one-cycle completion pulse. The serial side drives clock, data-out and an encoded chip-select value, and samples data-in. The serial clock follows SPI mode 0 and its rate is set by a parameter.

Top module: `dds_spi_engine`

## Requirements
- R1: The instruction word is sent MSB first as the first 16 serial bits. Its bit 15 is 1 for a read and 0 for a write, bits 14:13 hold the byte count minus one, and bits 12:0 hold `req_addr`.
- R2: A register request with `req_len` outside 1..4 is rejected. For a rejected request `rsp_done` pulses with `rsp_err` set, chip-select stays 0 and no serial clock edge occurs.
- R3: On a write of N bytes, the top N×8 bits of `req_wdata` follow the instruction MSB first, for a total of 16+8N serial clocks.
- R4: On a read of N bytes, the block samples N×8 data bits after the instruction. `rsp_rdata` returns them with the first sampled bit as the most significant, zero-extended above bit N×8−1. Bits present on `spi_miso` during the instruction phase are discarded.
- R5: A profile update (`req_profile`=1) ignores `req_len` and `req_read`. It sends the instruction {0, 2'b11, PHASE_ADDR}, then 16 bits of `req_pow`, then 48 bits of `req_ftw`, all MSB first: 80 serial clocks in total.
- R6: After a profile burst, `io_update` is high for exactly IOUPD_CYCLES clocks, only while chip-select is 0. It never rises for register reads or writes.
- R7: `spi_cs` equals CS_CODE (an encoded value from 4 to 7) for the whole instruction and data phases and is 0 otherwise. `spi_sclk` is low whenever `spi_cs` is 0.
- R8: Each serial clock phase (low, then high) lasts SCLK_HALF clocks. `spi_mosi` never changes while `spi_sclk` is high. `spi_miso` is sampled on the rising edge.
- R9: `req_ready` is low from the cycle after acceptance until the transaction ends, including the IO-update pulse. `rsp_done` is a single-cycle pulse. `rsp_rdata` keeps its value until the next read completes, so writes leave it unchanged.
- R10: `rsp_err` is 0 for every accepted transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 32 | Write data, left-justified |
| req_len | input | 3 | Byte count, 1..4 valid |
| req_read | input | 1 | 1 = read, 0 = write |
| req_profile | input | 1 | 1 = streaming phase/frequency update |
| req_pow | input | 16 | Phase word for profile update |
| req_ftw | input | 48 | Frequency tuning word for profile update |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Set with `rsp_done` when the request was rejected |
| rsp_rdata | output | 32 | Last read result, right-aligned |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |
| spi_cs | output | 3 | Encoded chip-select, 0 when idle |
| io_update | output | 1 | Strobe that applies profile data |

## Verification
The bench builds the engine with SCLK_HALF=2, so the counter-based clock divider variant is used rather than the single-cycle bypass. It also sets CS_CODE=5, which shows the encoded select is not simply the reset default, and IOUPD_CYCLES=3, which makes the strobe width distinguishable from one cycle. With these values even the 80-bit profile burst stays short, so every byte count, both data directions, rejected lengths and profile updates with a garbage length all fit into a brief run. Throughout the run, a per-clock monitor checks the serial-clock phase lengths and the timing of the MOSI and IO-update signals.

// File: rtl/dds_spi_pkg.sv
package dds_spi_pkg;
   localparam int INSTR_W   = 16;
   localparam int RD_BIT    = 15;
   localparam int LEN_LSB   = 13;
   localparam int WORD_W    = 32;
   localparam int POW_W     = 16;
   localparam int FTW_W     = 48;
   localparam int FRAME_W   = INSTR_W + POW_W + FTW_W;
   localparam int CNT_W     = $clog2(FRAME_W + 1);
   localparam int MAX_BYTES = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOW   = 2'd1,
      ST_HIGH  = 2'd2,
      ST_PULSE = 2'd3
   } eng_state_t;
endpackage

// File: rtl/dds_cmd_builder.sv
module dds_cmd_builder
   import dds_spi_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int PHASE_ADDR = 13'h01AD
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [WORD_W-1:0]  wdata,
   input  logic [2:0]         len,
   input  logic               rd,
   input  logic               profile,
   input  logic [POW_W-1:0]   pow,
   input  logic [FTW_W-1:0]   ftw,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   total_bits,
   output logic [CNT_W-1:0]   data_bits,
   output logic               len_ok
);
   localparam logic [ADDR_W-1:0] PH_ADDR = ADDR_W'(PHASE_ADDR);

   logic [1:0]         len_m1;
   logic [INSTR_W-1:0] instr;

   assign len_m1 = len[1:0] - 2'd1;
   assign len_ok = profile || (len >= 3'd1 && len <= 3'(MAX_BYTES));

   always_comb begin
      if (profile) begin
         instr      = {1'b0, 2'b11, PH_ADDR};
         frame      = {instr, pow, ftw};
         data_bits  = CNT_W'(POW_W + FTW_W);
      end else begin
         instr      = {rd, len_m1, addr};
         frame      = {instr, (rd ? '0 : wdata), {(FRAME_W-INSTR_W-WORD_W){1'b0}}};
         data_bits  = CNT_W'({len, 3'b000});
      end
      total_bits = data_bits + CNT_W'(INSTR_W);
   end
endmodule

// File: rtl/dds_sclk_timer.sv
module dds_sclk_timer #(
   parameter int SCLK_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (SCLK_HALF == 1) begin : g_bypass
         assign tick = run;
      end else begin : g_count
         localparam int DW = $clog2(SCLK_HALF);
         localparam logic [DW-1:0] LAST = DW'(SCLK_HALF - 1);
         logic [DW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run)         cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/dds_pulse_gen.sv
module dds_pulse_gen #(
   parameter int CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse,
   output logic last
);
   localparam int PW = $clog2(CYCLES + 1);
   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (fire)       cnt <= PW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign pulse = (cnt != '0);
   assign last  = (cnt == PW'(1));
endmodule

// File: rtl/dds_spi_engine.sv
module dds_spi_engine
   import dds_spi_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int SCLK_HALF    = 4,
   parameter int CS_CODE      = 4,
   parameter int IOUPD_CYCLES = 3,
   parameter int PHASE_ADDR   = 13'h01AD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic [2:0]        req_len,
   input  logic              req_read,
   input  logic              req_profile,
   input  logic [15:0]       req_pow,
   input  logic [47:0]       req_ftw,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [2:0]        spi_cs,
   output logic              io_update
);
   if (ADDR_W != LEN_LSB) begin : g_bad_addr
      $error("ADDR_W must equal the instruction address field width");
   end
   if (CS_CODE < 4 || CS_CODE > 7) begin : g_bad_cs
      $error("CS_CODE must lie in 4..7");
   end
   if (SCLK_HALF < 1) begin : g_bad_half
      $error("SCLK_HALF must be at least 1");
   end
   if (IOUPD_CYCLES < 1) begin : g_bad_pulse
      $error("IOUPD_CYCLES must be at least 1");
   end
   if (PHASE_ADDR >= (1 << LEN_LSB)) begin : g_bad_paddr
      $error("PHASE_ADDR does not fit the address field");
   end

   eng_state_t         state;
   logic [FRAME_W-1:0] shreg, frame;
   logic [CNT_W-1:0]   bits_left, dbits_q, total_bits, data_bits;
   logic               is_read, is_prof, len_ok;
   logic [WORD_W-1:0]  rx, rdata_q;
   logic               done_q, err_q, sclk_q;
   logic [2:0]         cs_q;
   logic               tick, run, fire, pulse, pulse_last;

   dds_cmd_builder #(.ADDR_W(ADDR_W), .PHASE_ADDR(PHASE_ADDR)) u_cmd (
      .addr(req_addr), .wdata(req_wdata), .len(req_len), .rd(req_read),
      .profile(req_profile), .pow(req_pow), .ftw(req_ftw),
      .frame(frame), .total_bits(total_bits), .data_bits(data_bits),
      .len_ok(len_ok)
   );

   assign run = (state == ST_LOW) || (state == ST_HIGH);

   dds_sclk_timer #(.SCLK_HALF(SCLK_HALF)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   assign fire = (state == ST_HIGH) && tick && (bits_left == CNT_W'(1)) && is_prof;

   dds_pulse_gen #(.CYCLES(IOUPD_CYCLES)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(pulse), .last(pulse_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bits_left <= '0;
         dbits_q   <= '0;
         is_read   <= 1'b0;
         is_prof   <= 1'b0;
         rx        <= '0;
         rdata_q   <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         sclk_q    <= 1'b0;
         cs_q      <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               if (!len_ok) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
               end else begin
                  shreg     <= frame;
                  bits_left <= total_bits;
                  dbits_q   <= data_bits;
                  is_read   <= req_read && !req_profile;
                  is_prof   <= req_profile;
                  rx        <= '0;
                  cs_q      <= 3'(CS_CODE);
                  state     <= ST_LOW;
               end
            end
            ST_LOW: if (tick) begin
               sclk_q <= 1'b1;
               if (is_read && bits_left <= dbits_q) rx <= {rx[WORD_W-2:0], spi_miso};
               state  <= ST_HIGH;
            end
            ST_HIGH: if (tick) begin
               sclk_q <= 1'b0;
               if (bits_left == CNT_W'(1)) begin
                  cs_q <= '0;
                  if (is_prof) begin
                     state <= ST_PULSE;
                  end else begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     if (is_read) rdata_q <= rx;
                  end
               end else begin
                  shreg     <= shreg << 1;
                  bits_left <= bits_left - 1'b1;
                  state     <= ST_LOW;
               end
            end
            ST_PULSE: if (pulse_last) begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_done  = done_q;
   assign rsp_err   = err_q;
   assign rsp_rdata = rdata_q;
   assign spi_sclk  = sclk_q;
   assign spi_mosi  = shreg[FRAME_W-1];
   assign spi_cs    = cs_q;
   assign io_update = pulse;
endmodule

module dds_spi_engine_chk #(
   parameter int CS_CODE = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       rsp_done,
   input logic       rsp_err,
   input logic       spi_sclk,
   input logic       spi_mosi,
   input logic [2:0] spi_cs,
   input logic       io_update
);
   a_r7_cs_code: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs == 3'd0) || (spi_cs == 3'(CS_CODE)));
   a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs == 3'd0) |-> !spi_sclk);
   a_r8_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |=> (!spi_sclk || $stable(spi_mosi)));
   a_r9_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs != 3'd0) |-> !req_ready);
   a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);
   a_r6_ioupd_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
      io_update |-> (spi_cs == 3'd0 && !req_ready));
   a_r10_err_only_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);
   a_r2_reject_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (spi_cs == 3'd0 && !spi_sclk));
endmodule

bind dds_spi_engine dds_spi_engine_chk #(.CS_CODE(CS_CODE)) u_chk (.*);

// File: tb/dds_spi_engine_tb.sv
module dds_spi_engine_tb;
   localparam int HALF  = 2;
   localparam int CS    = 5;
   localparam int IOUP  = 3;
   localparam int PADDR = 13'h01AD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [12:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [2:0]  req_len = '0;
   logic        req_read = 1'b0;
   logic        req_profile = 1'b0;
   logic [15:0] req_pow = '0;
   logic [47:0] req_ftw = '0;
   logic        rsp_done, rsp_err;
   logic [31:0] rsp_rdata;
   logic        spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;
   logic [2:0]  spi_cs;
   logic        io_update;

   always #2 clk = ~clk;

   dds_spi_engine #(.ADDR_W(13), .SCLK_HALF(HALF), .CS_CODE(CS),
                    .IOUPD_CYCLES(IOUP), .PHASE_ADDR(PADDR)) u_dut (.*);

   int tests = 0, fails = 0;
   bit cap[$];
   logic [31:0] rd_pat = '0;
   int k = 0;
   int cs_cycles = 0, io_cycles = 0, io_bad = 0, rdy_bad = 0, tviol = 0;
   logic got_err;
   logic [31:0] got_rdata;

   task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit miso_bit(input int idx);
      if (idx < 16) return 1'b1;
      if (idx - 16 < 32) return rd_pat[31 - (idx - 16)];
      return 1'b0;
   endfunction

   // Device model: drive data-in after each falling edge, record data-out on rising edges
   always @(spi_cs) if (spi_cs != 3'd0) begin k = 0; spi_miso = miso_bit(0); end
   always @(negedge spi_sclk) if (spi_cs != 3'd0) begin k++; spi_miso = miso_bit(k); end
   always @(posedge spi_sclk) if (spi_cs == 3'(CS)) cap.push_back(spi_mosi);

   // Per-clock reference of pin behaviour (R6, R7, R8, R9)
   logic p_sclk = 1'b0, p_mosi = 1'b0;
   int hi_run = 0, lo_run = 0;
   always @(negedge clk) if (rst_n) begin
      if (spi_cs != 3'd0) cs_cycles++;
      if (spi_cs != 3'd0 && spi_cs != 3'(CS)) tviol++;
      if (spi_cs == 3'd0 && spi_sclk) tviol++;
      if (spi_cs != 3'd0 && req_ready) rdy_bad++;
      if (io_update) begin io_cycles++; if (spi_cs != 3'd0) io_bad++; end
      if (spi_sclk) begin
         if (!p_sclk) begin if (lo_run != HALF) tviol++; hi_run = 1; end
         else begin hi_run++; if (spi_mosi !== p_mosi) tviol++; end
         lo_run = 0;
      end else begin
         if (p_sclk) begin if (hi_run != HALF) tviol++; end
         lo_run = (spi_cs != 3'd0) ? ((p_sclk) ? 1 : lo_run + 1) : 0;
      end
      p_sclk = spi_sclk;
      p_mosi = spi_mosi;
   end

   task automatic txn(input logic [12:0] a, input logic [31:0] wd, input logic [2:0] n,
                      input logic rd, input logic prof, input logic [15:0] pw, input logic [47:0] fw);
      int t;
      cap.delete();
      cs_cycles = 0; io_cycles = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_addr = a; req_wdata = wd; req_len = n; req_read = rd;
      req_profile = prof; req_pow = pw; req_ftw = fw; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!rsp_done && t < 3000) begin @(negedge clk); t++; end
      if (t >= 3000) chk("watchdog R9", 0, 1);
      got_err = rsp_err;
      got_rdata = rsp_rdata;
      @(negedge clk);
      chk("R9 done one cycle", {79'b0, rsp_done}, 80'd0);
   endtask

   function automatic logic [79:0] cap_vec(input int nb);
      logic [79:0] v = '0;
      for (int i = 0; i < nb && i < cap.size(); i++) v[79-i] = cap[i];
      return v;
   endfunction

   task automatic do_write(input logic [12:0] a, input logic [31:0] wd, input int n);
      logic [79:0] exp;
      txn(a, wd, 3'(n), 1'b0, 1'b0, '0, '0);
      exp = '0;
      exp[79:64] = {1'b0, 2'(n - 1), a};
      for (int i = 0; i < 8*n; i++) exp[63-i] = wd[31-i];
      chk("R3 write bit count", 80'(cap.size()), 80'(16 + 8*n));
      chk("R1 R3 write frame", cap_vec(16 + 8*n), exp);
      chk("R10 no err", {79'b0, got_err}, 80'd0);
      chk("R6 no io_update on write", 80'(io_cycles), 80'd0);
   endtask

   task automatic do_read(input logic [12:0] a, input logic [31:0] pat, input int n);
      logic [79:0] exp;
      rd_pat = pat;
      txn(a, 32'hFFFF_FFFF, 3'(n), 1'b1, 1'b0, '0, '0);
      exp = '0;
      exp[79:64] = {1'b1, 2'(n - 1), a};
      chk("R4 read bit count", 80'(cap.size()), 80'(16 + 8*n));
      chk("R1 read instruction", {cap_vec(16)[79:64], 64'b0}, exp);
      chk("R4 read data", 80'(got_rdata), 80'(pat >> (32 - 8*n)));
   endtask

   initial begin : main
      logic [31:0] keep;
      repeat (3) @(negedge clk);
      chk("R7 R9 reset state", {74'b0, req_ready, spi_cs, spi_sclk, io_update},
          {74'b0, 1'b1, 3'd0, 1'b0, 1'b0});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_write(13'h01A5, 32'hC300_0000, 1);
      do_write(13'h0010, 32'h1234_5678, 2);
      do_write(13'h1FFF, 32'hA5A5_0F0F, 3);
      do_write(13'h0000, 32'h8000_0001, 4);

      do_read(13'h0003, 32'hABCD_1234, 2);
      do_read(13'h0A0A, 32'h8765_4321, 4);
      do_read(13'h0101, 32'h5E00_0000, 1);
      do_read(13'h1234, 32'hFEDC_BA98, 3);

      keep = got_rdata;
      do_write(13'h0044, 32'h0BAD_F00D, 4);
      chk("R9 rdata kept across write", 80'(rsp_rdata), 80'(keep));

      txn(13'h0001, 32'hFFFF_FFFF, 3'd0, 1'b0, 1'b0, '0, '0);
      chk("R2 len0 rejected err", {79'b0, got_err}, 80'd1);
      chk("R2 len0 no cs", 80'(cs_cycles + cap.size()), 80'd0);
      txn(13'h0001, 32'hFFFF_FFFF, 3'd5, 1'b1, 1'b0, '0, '0);
      chk("R2 len5 rejected err", {79'b0, got_err}, 80'd1);
      chk("R2 len5 no cs", 80'(cs_cycles + cap.size()), 80'd0);
      chk("R2 rdata untouched by reject", 80'(rsp_rdata), 80'(keep));

      txn(13'h0, '0, 3'd2, 1'b0, 1'b1, 16'h3C5A, 48'h1234_5678_9ABC);
      chk("R5 profile bit count", 80'(cap.size()), 80'd80);
      chk("R5 profile frame", cap_vec(80), {1'b0, 2'b11, 13'(PADDR), 16'h3C5A, 48'h1234_5678_9ABC});
      chk("R6 io_update width", 80'(io_cycles), 80'(IOUP));
      chk("R10 profile no err", {79'b0, got_err}, 80'd0);
      txn(13'h0, '0, 3'd0, 1'b1, 1'b1, 16'hFFFF, 48'h8000_0000_0001);
      chk("R5 profile ignores len and read", cap_vec(80),
          {1'b0, 2'b11, 13'(PADDR), 16'hFFFF, 48'h8000_0000_0001});
      chk("R6 io_update width again", 80'(io_cycles), 80'(IOUP));

      chk("R6 io_update only with cs idle", 80'(io_bad), 80'd0);
      chk("R9 ready low while busy", 80'(rdy_bad), 80'd0);
      chk("R7 R8 sclk timing and mosi hold", 80'(tviol), 80'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog R9: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule